// File: doc/BRIEF.md
# Address-Range Memory Breakpoint Unit

This block sits beside a processor core and watches its program, X and Y address buses together with per-cycle access strobes. A 4-bit qualifier selects which class of access counts as a candidate. Candidate classes include program fetches, executed first-word fetches, explicit program-space data moves, and X or Y reads and writes. Every cycle the unit captures the matching bus address in a latch. It then tests that address against an inclusive, unsigned window set by a lower and an upper limit register.

A skip counter absorbs qualifying in-range hits before the unit raises a breakpoint request. While the counter is above zero, each hit decrements it. A hit that finds the counter at zero fires the request. A sticky occurrence flag records that the breakpoint fired. It stays set until the debug controller leaves debug mode with both its go and exit controls raised. Software loads the qualifier, the limits and the counter through a small write port with a 2-bit register select.

Top module: `mbp_unit`

## Requirements
- R1: After reset the qualifier is 0000, the lower and upper limits and the counter are zero, the occurrence flag is clear and no request is raised.
- R2: Qualifier 0000 and the reserved codes 1000 and 1100 never produce a hit, whatever the strobes and addresses.
- R3: Code 0001 matches any program fetch, aborted included (p_fetch_i or p_exec_i). Code 0010 matches any fetch or a program-space move read. Code 0011 matches any fetch or a program-space move read or write.
- R4: Code 0100 matches only p_exec_i, which marks the first word of an instruction that executes. A fetch flagged only by p_fetch_i (aborted, or a discarded prefetch) does not match.
- R5: Codes 0101, 0110 and 0111 match program-space moves only: a write, a read, and either, respectively. Fetches never match under these codes.
- R6: Codes 1001, 1010 and 1011 match an X write, an X read, and either. Codes 1101, 1110 and 1111 do the same for Y. In every data-space code, bit 0 enables writes and bit 1 enables reads. Qualifier bits [3:2] pick the bus whose address is latched: 0x selects the program bus, 10 selects X, 11 selects Y.
- R7: An address is in range when lower <= address <= upper, compared unsigned, with both limits inclusive. A window whose lower limit is above its upper limit never matches.
- R8: A qualified in-range hit decrements the counter when it is above zero and raises no request. A hit that finds the counter at zero leaves it at zero and raises the request. Out-of-range or unqualified accesses leave the counter unchanged.
- R9: Accesses presented in cycle n are latched at the following edge. The request bkpt_o is high in cycle n+1 for exactly one cycle, and only while the occurrence flag is clear. The flag is set at the edge that ends the request cycle.
- R10: The occurrence flag stays set until a cycle with both leave_go_i and leave_ex_i high. Either control alone does not clear it. Once the flag is clear, a new hit with the counter at zero fires again.
- R11: The write port loads a register when wr_en_i is high. Select 00 loads the qualifier from wr_data_i[3:0], 01 the lower limit, 10 the upper limit and 11 the counter. A counter write takes precedence over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| p_addr_i | input | 16 | Program address bus |
| x_addr_i | input | 16 | X data address bus |
| y_addr_i | input | 16 | Y data address bus |
| p_fetch_i | input | 1 | Program fetch of any kind, aborted included |
| p_exec_i | input | 1 | First-word fetch of an instruction that executes |
| p_rd_i | input | 1 | Explicit program-space move read |
| p_wr_i | input | 1 | Explicit program-space move write |
| x_rd_i | input | 1 | X-space read |
| x_wr_i | input | 1 | X-space write |
| y_rd_i | input | 1 | Y-space read |
| y_wr_i | input | 1 | Y-space write |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 16 | Register write data |
| leave_go_i | input | 1 | Debug-mode exit: go control |
| leave_ex_i | input | 1 | Debug-mode exit: exit control |
| bkpt_o | output | 1 | Breakpoint request, one-cycle pulse |
| occur_o | output | 1 | Sticky breakpoint occurrence flag |

## Verification
The assertions check the following on every cycle:
- the reserved and disabled codes never produce a latched hit;
- an inverted window never reports in range;
- each counted hit lowers the counter by one;
- the request lasts one cycle and always sets the flag;
- the flag holds until both exit controls are seen.

Only the bench scenarios can show the rest. Each of the sixteen codes has to be paired with the right strobe and bus to confirm that it selects them. The exact count of absorbed hits and the inclusive window edges also need concrete address sequences with known outcomes.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  typedef enum logic [3:0] {
    Q_OFF      = 4'h0,
    Q_FETCH    = 4'h1,
    Q_P_READ   = 4'h2,
    Q_P_ANY    = 4'h3,
    Q_EXEC     = 4'h4,
    Q_PMV_WR   = 4'h5,
    Q_PMV_RD   = 4'h6,
    Q_PMV_RW   = 4'h7,
    Q_RSV_X    = 4'h8,
    Q_X_WR     = 4'h9,
    Q_X_RD     = 4'hA,
    Q_X_RW     = 4'hB,
    Q_RSV_Y    = 4'hC,
    Q_Y_WR     = 4'hD,
    Q_Y_RD     = 4'hE,
    Q_Y_RW     = 4'hF
  } qual_e;

  typedef enum logic [1:0] {
    SEL_QUAL = 2'b00,
    SEL_LO   = 2'b01,
    SEL_HI   = 2'b10,
    SEL_CNT  = 2'b11
  } sel_e;

  typedef struct packed {
    logic p_fetch;
    logic p_exec;
    logic p_rd;
    logic p_wr;
    logic x_rd;
    logic x_wr;
    logic y_rd;
    logic y_wr;
  } acc_t;

endpackage

// File: rtl/mbp_qual.sv
module mbp_qual
  import mbp_pkg::*;
#(
  parameter int AW = 16
) (
  input  qual_e         code_i,
  input  acc_t          acc_i,
  input  logic [AW-1:0] p_addr_i,
  input  logic [AW-1:0] x_addr_i,
  input  logic [AW-1:0] y_addr_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);

  logic [1:0] space;
  logic       rd_s, wr_s, any_fetch;

  assign space     = code_i[3:2];
  assign any_fetch = acc_i.p_fetch | acc_i.p_exec;

  // bus selection: 0x program, 10 X, 11 Y
  always_comb begin
    unique case (space)
      2'b10:   addr_o = x_addr_i;
      2'b11:   addr_o = y_addr_i;
      default: addr_o = p_addr_i;
    endcase
  end

  always_comb begin
    unique case (space)
      2'b01:   begin rd_s = acc_i.p_rd; wr_s = acc_i.p_wr; end
      2'b10:   begin rd_s = acc_i.x_rd; wr_s = acc_i.x_wr; end
      2'b11:   begin rd_s = acc_i.y_rd; wr_s = acc_i.y_wr; end
      default: begin rd_s = 1'b0;       wr_s = 1'b0;       end
    endcase
  end

  always_comb begin
    hit_o = 1'b0;
    if (space == 2'b00) begin
      unique case (code_i[1:0])
        2'b01:   hit_o = any_fetch;
        2'b10:   hit_o = any_fetch | acc_i.p_rd;
        2'b11:   hit_o = any_fetch | acc_i.p_rd | acc_i.p_wr;
        default: hit_o = 1'b0;
      endcase
    end else if (code_i == Q_EXEC) begin
      hit_o = acc_i.p_exec;
    end else begin
      // bit0 enables writes, bit1 reads; reserved 1000/1100 give zero
      hit_o = (code_i[0] & wr_s) | (code_i[1] & rd_s);
    end
  end

endmodule

// File: rtl/mbp_latch.sv
module mbp_latch #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      hit_o  <= hit_i;
      addr_o <= addr_i;
    end
  end

endmodule

// File: rtl/mbp_range.sv
module mbp_range #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          in_range_o
);

  logic [1:0] cmp;

  // cmp[0]: at or above lower limit, cmp[1]: at or below upper limit
  for (genvar g = 0; g < 2; g++) begin : g_cmp
    if (g == 0) begin : g_low
      assign cmp[g] = (addr_i >= lo_i);
    end else begin : g_high
      assign cmp[g] = (addr_i <= hi_i);
    end
  end

  assign in_range_o = &cmp;

  // R7
  inverted_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_i > hi_i) |-> !in_range_o);

endmodule

// File: rtl/mbp_cnt.sv
module mbp_cnt #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          in_range_i,
  input  logic          wr_cnt_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          leave_i,
  output logic          fire_o,
  output logic          occur_o
);

  logic [AW-1:0] cnt_q;
  logic          match, zero;

  assign match  = hit_i & in_range_i;
  assign zero   = (cnt_q == '0);
  assign fire_o = match & zero & ~occur_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q <= wr_data_i;
    end else if (match && !zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // setting wins over a same-cycle exit request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occur_o <= 1'b0;
    end else if (fire_o) begin
      occur_o <= 1'b1;
    end else if (leave_i) begin
      occur_o <= 1'b0;
    end
  end

  // R8
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !zero && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  fire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  // R9
  fire_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> occur_o);

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occur_o && !leave_i) |=> occur_o);

endmodule

// File: rtl/mbp_unit.sv
module mbp_unit
  import mbp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] p_addr_i,
  input  logic [AW-1:0] x_addr_i,
  input  logic [AW-1:0] y_addr_i,
  input  logic          p_fetch_i,
  input  logic          p_exec_i,
  input  logic          p_rd_i,
  input  logic          p_wr_i,
  input  logic          x_rd_i,
  input  logic          x_wr_i,
  input  logic          y_rd_i,
  input  logic          y_wr_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          leave_go_i,
  input  logic          leave_ex_i,
  output logic          bkpt_o,
  output logic          occur_o
);

  localparam int QW = 4;

  qual_e         qual_q;
  logic [AW-1:0] lo_q, hi_q;
  acc_t          acc;
  logic          hit_d, hit_q, in_range;
  logic [AW-1:0] addr_d, addr_q;
  logic          wr_cnt;

  assign acc = '{p_fetch: p_fetch_i, p_exec: p_exec_i, p_rd: p_rd_i, p_wr: p_wr_i,
                 x_rd: x_rd_i, x_wr: x_wr_i, y_rd: y_rd_i, y_wr: y_wr_i};

  assign wr_cnt = wr_en_i && (sel_e'(wr_sel_i) == SEL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q <= Q_OFF;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (wr_en_i) begin
      unique case (sel_e'(wr_sel_i))
        SEL_QUAL: qual_q <= qual_e'(wr_data_i[QW-1:0]);
        SEL_LO:   lo_q   <= wr_data_i;
        SEL_HI:   hi_q   <= wr_data_i;
        default:  ;
      endcase
    end
  end

  mbp_qual #(.AW(AW)) u_qual (
    .code_i  (qual_q),
    .acc_i   (acc),
    .p_addr_i(p_addr_i),
    .x_addr_i(x_addr_i),
    .y_addr_i(y_addr_i),
    .hit_o   (hit_d),
    .addr_o  (addr_d)
  );

  mbp_latch #(.AW(AW)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit_d),
    .addr_i(addr_d),
    .hit_o (hit_q),
    .addr_o(addr_q)
  );

  mbp_range #(.AW(AW)) u_range (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_q),
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .in_range_o(in_range)
  );

  mbp_cnt #(.AW(AW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit_q),
    .in_range_i(in_range),
    .wr_cnt_i  (wr_cnt),
    .wr_data_i (wr_data_i),
    .leave_i   (leave_go_i & leave_ex_i),
    .fire_o    (bkpt_o),
    .occur_o   (occur_o)
  );

  // R2
  reserved_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_q == Q_OFF || qual_q == Q_RSV_X || qual_q == Q_RSV_Y) |=> !hit_q);

  // R9
  no_req_when_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occur_o |-> !bkpt_o);

endmodule

// File: tb/sim_mbp_unit.sv
`timescale 1ns/1ps
module sim_mbp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pa = '0, xa = '0, ya = '0;
  logic [7:0]  strb = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        lgo = 1'b0, lex = 1'b0;
  logic        bkpt, occur;

  int n_tot = 0;
  int n_ok  = 0;

  // strobe bit positions
  localparam logic [7:0] S_FETCH = 8'h80, S_EXEC = 8'h40, S_PRD = 8'h20, S_PWR = 8'h10,
                         S_XRD = 8'h08, S_XWR = 8'h04, S_YRD = 8'h02, S_YWR = 8'h01;

  always #2.5 clk = ~clk;

  mbp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .p_addr_i(pa), .x_addr_i(xa), .y_addr_i(ya),
    .p_fetch_i(strb[7]), .p_exec_i(strb[6]), .p_rd_i(strb[5]), .p_wr_i(strb[4]),
    .x_rd_i(strb[3]), .x_wr_i(strb[2]), .y_rd_i(strb[1]), .y_wr_i(strb[0]),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .leave_go_i(lgo), .leave_ex_i(lex),
    .bkpt_o(bkpt), .occur_o(occur)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_tot++;
    if (act === exp) n_ok++;
    else $display("FAIL %s: actual %0b expected %0b", req, act, exp);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic leave(input logic g, input logic e);
    @(negedge clk);
    lgo = g; lex = e;
    @(negedge clk);
    lgo = 1'b0; lex = 1'b0;
  endtask

  task automatic setup(input logic [3:0] code, input logic [15:0] lo, input logic [15:0] hi,
                       input logic [15:0] cnt);
    wreg(2'b00, {12'h0, code});
    wreg(2'b01, lo);
    wreg(2'b10, hi);
    wreg(2'b11, cnt);
    leave(1'b1, 1'b1);
  endtask

  // present an access for one cycle; sample the request one cycle later
  task automatic acc(input logic [7:0] s, input logic [15:0] p, input logic [15:0] x,
                     input logic [15:0] y, output logic fired);
    @(negedge clk);
    strb = s; pa = p; xa = x; ya = y;
    @(negedge clk);
    strb = '0;
    fired = bkpt;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(bkpt, 1'b0, "R1 no request after reset");
    chk(occur, 1'b0, "R1 flag clear after reset");
    begin
      logic f;
      acc(8'hFF, 16'h0000, 16'h0000, 16'h0000, f);
      chk(f, 1'b0, "R1 qualifier 0000 after reset");
    end
  endtask

  task automatic t_disabled();
    logic f;
    setup(4'h0, 16'h0000, 16'hFFFF, 16'h0);
    acc(8'hFF, 16'h1234, 16'h1234, 16'h1234, f);
    chk(f, 1'b0, "R2 code 0000");
    setup(4'h8, 16'h0000, 16'hFFFF, 16'h0);
    acc(8'hFF, 16'h1234, 16'h1234, 16'h1234, f);
    chk(f, 1'b0, "R2 code 1000");
    setup(4'hC, 16'h0000, 16'hFFFF, 16'h0);
    acc(8'hFF, 16'h1234, 16'h1234, 16'h1234, f);
    chk(f, 1'b0, "R2 code 1100");
  endtask

  task automatic t_prog_any();
    logic f;
    setup(4'h1, 16'h0100, 16'h01FF, 16'h0);
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R3 code 0001 aborted fetch");
    setup(4'h1, 16'h0100, 16'h01FF, 16'h0);
    acc(S_PRD, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R3 code 0001 ignores move read");
    setup(4'h2, 16'h0100, 16'h01FF, 16'h0);
    acc(S_PWR, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R3 code 0010 ignores move write");
    acc(S_PRD, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R3 code 0010 move read");
    setup(4'h3, 16'h0100, 16'h01FF, 16'h0);
    acc(S_PWR, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R3 code 0011 move write");
  endtask

  task automatic t_exec();
    logic f;
    setup(4'h4, 16'h0100, 16'h01FF, 16'h0);
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R4 discarded fetch ignored");
    acc(S_PRD, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R4 move read ignored");
    acc(S_EXEC | S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R4 executed fetch");
  endtask

  task automatic t_pmove();
    logic f;
    setup(4'h5, 16'h0100, 16'h01FF, 16'h0);
    acc(S_FETCH | S_EXEC | S_PRD, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R5 code 0101 ignores fetch and read");
    acc(S_PWR, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R5 code 0101 write");
    setup(4'h6, 16'h0100, 16'h01FF, 16'h0);
    acc(S_PWR, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R5 code 0110 ignores write");
    acc(S_PRD, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R5 code 0110 read");
    setup(4'h7, 16'h0100, 16'h01FF, 16'h0);
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R5 code 0111 ignores fetch");
    acc(S_PWR, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R5 code 0111 write");
  endtask

  task automatic t_data();
    logic f;
    setup(4'hA, 16'h2000, 16'h2FFF, 16'h0);
    acc(S_XWR, 16'h0, 16'h2400, 16'h0, f);
    chk(f, 1'b0, "R6 code 1010 ignores X write");
    acc(S_XRD, 16'h2400, 16'h5000, 16'h2400, f);
    chk(f, 1'b0, "R6 X bus address used");
    acc(S_XRD, 16'h0, 16'h2400, 16'h0, f);
    chk(f, 1'b1, "R6 code 1010 X read");
    setup(4'hD, 16'h2000, 16'h2FFF, 16'h0);
    acc(S_XWR | S_YRD, 16'h0, 16'h2400, 16'h2400, f);
    chk(f, 1'b0, "R6 code 1101 ignores X write and Y read");
    acc(S_YWR, 16'h0, 16'h0, 16'h2400, f);
    chk(f, 1'b1, "R6 code 1101 Y write");
    setup(4'hF, 16'h2000, 16'h2FFF, 16'h0);
    acc(S_YRD, 16'h0, 16'h0, 16'h2FFF, f);
    chk(f, 1'b1, "R6 code 1111 Y read");
  endtask

  task automatic t_range();
    logic f;
    setup(4'h1, 16'h8000, 16'h80FF, 16'h0);
    acc(S_FETCH, 16'h7FFF, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R7 below lower");
    acc(S_FETCH, 16'h8100, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R7 above upper (unsigned)");
    acc(S_FETCH, 16'h8000, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R7 equal lower");
    setup(4'h1, 16'h8000, 16'h80FF, 16'h0);
    acc(S_FETCH, 16'h80FF, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R7 equal upper");
    setup(4'h1, 16'h0200, 16'h0100, 16'h0);
    acc(S_FETCH, 16'h0180, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R7 inverted window");
    acc(S_FETCH, 16'h0200, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R7 inverted window at lower");
  endtask

  task automatic t_count();
    logic f;
    setup(4'h1, 16'h0100, 16'h01FF, 16'd2);
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R8 first hit absorbed");
    acc(S_FETCH, 16'h0300, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R8 out of range");
    acc(S_PRD, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R8 unqualified");
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R8 second hit absorbed");
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R8 third hit fires");
  endtask

  task automatic t_pulse_flag();
    setup(4'h1, 16'h0100, 16'h01FF, 16'h0);
    @(negedge clk);
    strb = S_FETCH; pa = 16'h0120;
    @(negedge clk);
    pa = 16'h0121;
    chk(bkpt, 1'b1, "R9 request one cycle after access");
    chk(occur, 1'b0, "R9 flag not yet set");
    @(negedge clk);
    strb = '0;
    chk(bkpt, 1'b0, "R9 request one cycle only");
    chk(occur, 1'b1, "R9 flag set");
    @(negedge clk);
    chk(bkpt, 1'b0, "R9 no request while flag set");
    leave(1'b1, 1'b0);
    chk(occur, 1'b1, "R10 go alone keeps flag");
    leave(1'b0, 1'b1);
    chk(occur, 1'b1, "R10 exit alone keeps flag");
    leave(1'b1, 1'b1);
    chk(occur, 1'b0, "R10 go and exit clear flag");
    begin
      logic f;
      acc(S_FETCH, 16'h0130, 16'h0, 16'h0, f);
      chk(f, 1'b1, "R10 fires again after clear");
    end
  endtask

  task automatic t_write_prio();
    logic f;
    setup(4'h1, 16'h0100, 16'h01FF, 16'd5);
    // hit latched in the same cycle as the counter write of 1
    @(negedge clk);
    strb = S_FETCH; pa = 16'h0150;
    @(negedge clk);
    strb = '0;
    wr_en = 1'b1; wr_sel = 2'b11; wr_data = 16'd1;
    @(negedge clk);
    wr_en = 1'b0;
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b0, "R11 counter write wins over decrement");
    acc(S_FETCH, 16'h0150, 16'h0, 16'h0, f);
    chk(f, 1'b1, "R11 written count honoured");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_prog_any();
    t_exec();
    t_pmove();
    t_data();
    t_range();
    t_count();
    t_pulse_flag();
    t_write_prio();
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end

endmodule